// File: doc/BRIEF.md
# AC'97 link SYNC pulse controller

This block produces the SYNC output of an AC'97 link. Three sources can drive the line. Listed by priority, from highest to lowest, they are:

- a level that software sets directly;
- a one-shot pulse timed against a slow reference clock;
- the normal frame generator, which counts BITCLK rising edges.

Software selects a source through one control register on a simple read/write bus. The one-shot pulse clears its own request bit when it finishes. The register read shows that bit's live value, so software can poll it to learn when the pulse has ended.

Everything runs on one register clock `clk`. The reference clock and BITCLK are sampled as data. Each passes through a two-flop synchronizer, and a rise detector finds its rising edges.

The one-shot is a state machine with two states, `OS_IDLE` and `OS_PULSE`:
- `OS_IDLE` moves to `OS_PULSE` when it sees the timed bit set.
- `OS_PULSE` returns to `OS_IDLE` on the reference rising edge that completes the pulse. In that same cycle it raises the clear strobe.

The frame generator is a state machine with two states, `FR_SYNC` and `FR_SLOTS`:
- `FR_SYNC` moves to `FR_SLOTS` on the BITCLK edge that ends the 16-edge high window.
- `FR_SLOTS` moves to `FR_SYNC` on the edge that wraps the 256-edge frame.

The output multiplexer selects one of three sources: `SRC_FORCED`, `SRC_TIMED` or `SRC_FRAME`.

Top module: `ac97_sync_ctrl`

## Requirements
- R1: After reset the control register reads 0. The one-shot is idle. The frame counter is at the start of a frame, so `sync_out` is 1.
- R2: The control register sits at address `CTRL_ADDR`, which is 4 by default. Its bits are as follows. Bit 2 enables forced mode. Bit 1 is the forced level. Bit 0 requests the timed pulse. All higher bits read as 0, and writes to them are ignored. A read of any other address returns 0.
- R3: While bit 2 is 1, `sync_out` equals bit 1. This holds whatever the timed pulse and the frame generator are doing.
- R4: While bit 2 is 0, the value of bit 1 has no effect on `sync_out`.
- R5: Software requests the timed pulse by writing 1 to bit 0 while forced mode is off. `sync_out` is then 1 from the cycle after the write. It stays 1 until the fifth detected reference rising edge after the pulse starts. The high time is therefore between 4 and 5 reference periods, allowing a few cycles of synchronizer latency.
- R6: Bit 0 reads 1 while the pulse runs and 0 after hardware clears it. Writing 0 to bit 0 does not cancel a running pulse. Writing 1 again during a pulse does not lengthen it.
- R7: Once the timed pulse has ended, `sync_out` follows the frame generator again.
- R8: In normal mode a frame lasts 256 BITCLK rising edges. `sync_out` is 1 for the first 16 edges of each frame and 0 for the rest.
- R9: A timed request made while forced mode is on still runs and still clears bit 0. Throughout it, `sync_out` keeps the forced level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data; reflects `bus_addr` in the same cycle |
| ref_clk_in | input | 1 | Slow reference clock that times the one-shot pulse |
| bitclk_in | input | 1 | AC'97 bit clock that steps the frame generator |
| sync_out | output | 1 | SYNC line to the codec |

## Verification
The assertions take two things for granted.

- Both `ref_clk_in` and `bitclk_in` change far more slowly than `clk`. Each high and each low phase therefore spans at least three register cycles, so the synchronizers see every edge exactly once.
- A write that sets bit 0 is not expected in the same cycle as the hardware clear.

The stimulus stays within these conditions in three ways. The reference clock half-period is 20 register cycles. Each BITCLK edge is held for three cycles. The tests that depend on the pulse always wait for bit 0 to read 0 before they request another pulse.

// File: rtl/ac97_sync_pkg.sv
package ac97_sync_pkg;

    localparam int unsigned BIT_TIMED     = 0;
    localparam int unsigned BIT_FORCE_LVL = 1;
    localparam int unsigned BIT_FORCE_EN  = 2;
    localparam int unsigned CTRL_BITS     = 3;

    typedef struct packed {
        logic force_en;
        logic force_lvl;
        logic timed;
    } sync_ctrl_t;

    typedef enum logic {
        OS_IDLE,
        OS_PULSE
    } oneshot_state_t;

    typedef enum logic {
        FR_SYNC,
        FR_SLOTS
    } frame_state_t;

    typedef enum logic [1:0] {
        SRC_FORCED,
        SRC_TIMED,
        SRC_FRAME
    } sync_src_t;

endpackage

// File: rtl/ac97_sync_edge.sv
module ac97_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-1:0], async_in};
        end
    end

    always_comb begin
        rise = shift_q[STAGES-1] & ~shift_q[STAGES];
    end

endmodule

// File: rtl/ac97_sync_regs.sv
module ac97_sync_regs
    import ac97_sync_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pulse_done,
    output sync_ctrl_t        ctrl
);

    logic hit;
    logic hit_wr;

    always_comb begin
        hit    = (bus_addr == CTRL_ADDR);
        hit_wr = hit && bus_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (hit_wr) begin
                ctrl.force_en  <= bus_wdata[BIT_FORCE_EN];
                ctrl.force_lvl <= bus_wdata[BIT_FORCE_LVL];
            end
            if (pulse_done) begin
                ctrl.timed <= 1'b0;
            end else if (hit_wr && bus_wdata[BIT_TIMED]) begin
                ctrl.timed <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[CTRL_BITS-1:0] = ctrl;
        end
    end

    // R6: a write of 0 to the timed bit must not cancel a running pulse
    a_r6_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && !bus_wdata[BIT_TIMED] && ctrl.timed && !pulse_done) |=> ctrl.timed);

    // R6: the timed bit only falls after the one-shot reports completion
    a_r6_clear_by_hw: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.timed) |-> $past(pulse_done));

endmodule

// File: rtl/ac97_sync_oneshot.sv
module ac97_sync_oneshot
    import ac97_sync_pkg::*;
#(
    parameter int unsigned PULSE_EDGES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic timed_req,
    input  logic ref_rise,
    output logic pulse_done
);

    localparam int unsigned CNT_W = $clog2(PULSE_EDGES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_EDGES - 1);

    oneshot_state_t state_q, state_nx;
    logic [CNT_W-1:0] edge_cnt_q;
    logic             last_edge;

    always_comb begin
        last_edge = ref_rise && (edge_cnt_q == LAST);
        state_nx  = state_q;
        unique case (state_q)
            OS_IDLE:  if (timed_req) state_nx = OS_PULSE;
            OS_PULSE: if (last_edge) state_nx = OS_IDLE;
            default:  state_nx = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= OS_IDLE;
            edge_cnt_q <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == OS_IDLE || last_edge) begin
                edge_cnt_q <= '0;
            end else if (ref_rise) begin
                edge_cnt_q <= edge_cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        pulse_done = (state_q == OS_PULSE) && last_edge;
    end

    // R5: the edge counter never passes the final edge of the pulse
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt_q <= LAST);

    // R6: a running pulse always has its request bit still set
    a_r6_pulse_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OS_PULSE) |-> timed_req);

endmodule

// File: rtl/ac97_sync_frame.sv
module ac97_sync_frame
    import ac97_sync_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 256,
    parameter int unsigned SYNC_LEN  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_rise,
    output logic frame_sync
);

    localparam int unsigned CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] SYNC_LAST  = CNT_W'(SYNC_LEN - 1);

    frame_state_t     state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FR_SYNC:  if (bit_rise && cnt_q == SYNC_LAST)  state_nx = FR_SLOTS;
            FR_SLOTS: if (bit_rise && cnt_q == FRAME_LAST) state_nx = FR_SYNC;
            default:  state_nx = FR_SYNC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_SYNC;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (bit_rise) begin
                cnt_q <= (cnt_q == FRAME_LAST) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        frame_sync = (state_q == FR_SYNC);
    end

    // R8: SYNC high only inside the first SYNC_LEN positions of a frame
    a_r8_sync_window: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |-> (cnt_q <= SYNC_LAST));

    // R8: the frame position advances only on a BITCLK rising edge
    a_r8_step_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_rise) |-> $stable(cnt_q));

endmodule

// File: rtl/ac97_sync_ctrl.sv
module ac97_sync_ctrl
    import ac97_sync_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4,
    parameter int unsigned PULSE_EDGES = 5,
    parameter int unsigned FRAME_LEN   = 256,
    parameter int unsigned SYNC_LEN    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_clk_in,
    input  logic              bitclk_in,
    output logic              sync_out
);

    sync_ctrl_t ctrl;
    logic       pulse_done;
    logic       ref_rise;
    logic       bit_rise;
    logic       frame_sync;
    sync_src_t  src;

    ac97_sync_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pulse_done(pulse_done), .ctrl(ctrl)
    );

    ac97_sync_edge #(.STAGES(SYNC_STAGES)) ref_edge_i (
        .clk(clk), .rst_n(rst_n), .async_in(ref_clk_in), .rise(ref_rise)
    );

    ac97_sync_edge #(.STAGES(SYNC_STAGES)) bit_edge_i (
        .clk(clk), .rst_n(rst_n), .async_in(bitclk_in), .rise(bit_rise)
    );

    ac97_sync_oneshot #(.PULSE_EDGES(PULSE_EDGES)) oneshot_i (
        .clk(clk), .rst_n(rst_n), .timed_req(ctrl.timed),
        .ref_rise(ref_rise), .pulse_done(pulse_done)
    );

    ac97_sync_frame #(.FRAME_LEN(FRAME_LEN), .SYNC_LEN(SYNC_LEN)) frame_i (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .frame_sync(frame_sync)
    );

    always_comb begin
        if (ctrl.force_en)   src = SRC_FORCED;
        else if (ctrl.timed) src = SRC_TIMED;
        else                 src = SRC_FRAME;
    end

    always_comb begin
        unique case (src)
            SRC_FORCED: sync_out = ctrl.force_lvl;
            SRC_TIMED:  sync_out = 1'b1;
            SRC_FRAME:  sync_out = frame_sync;
            default:    sync_out = frame_sync;
        endcase
    end

    // R3: a completed one-shot cannot disturb a forced level
    a_r3_forced_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.force_en && $past(ctrl.force_en) && $stable(ctrl.force_lvl))
            |-> $stable(sync_out));

endmodule

// File: tb/ac97_sync_ctrl_tb_top.sv
`timescale 1ns/1ps
module ac97_sync_ctrl_tb_top;

    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned DATA_W   = 32;
    localparam logic [ADDR_W-1:0] CTRL_A = 4;
    localparam int REF_HALF = 20;
    localparam int REF_P    = 2 * REF_HALF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = CTRL_A;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              ref_clk_in = 1'b0;
    logic              bitclk_in = 1'b0;
    logic              sync_out;

    int checks = 0;
    int errors = 0;
    int bit_edges = 0;
    bit done_flag = 0;

    ac97_sync_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ref_clk_in(ref_clk_in), .bitclk_in(bitclk_in), .sync_out(sync_out)
    );

    always #4 clk = ~clk;

    initial begin
        #3;
        forever begin
            #(REF_HALF * 8) ref_clk_in = ~ref_clk_in;
        end
    end

    function automatic logic frame_model(int edges);
        return ((edges % 256) < 16);
    endfunction

    function automatic logic sync_model(logic fen, logic flv, logic tmd, int edges);
        if (fen) return flv;
        if (tmd) return 1'b1;
        return frame_model(edges);
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr  = CTRL_A;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = CTRL_A;
    endtask

    task automatic bit_rise();
        @(negedge clk);
        bitclk_in = 1'b1;
        repeat (3) @(negedge clk);
        bitclk_in = 1'b0;
        repeat (3) @(negedge clk);
        bit_edges++;
    endtask

    task automatic wait_timed_clear(int limit, output int cyc);
        logic [DATA_W-1:0] d;
        cyc = 0;
        rd(CTRL_A, d);
        while (d[0] && cyc < limit) begin
            @(negedge clk);
            cyc++;
            rd(CTRL_A, d);
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [DATA_W-1:0] d;
        int width;
        int cyc;
        logic fen, flv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CTRL_A, d);
        check("R1 reg after reset", d, 0);
        check("R1 sync at frame start", sync_out, 1);

        // R2 reserved bits and other address
        wr(32'hFFFF_FFF8);
        rd(CTRL_A, d);
        check("R2 reserved bits read 0", d, 0);
        wr(32'h0000_0006);
        rd(4'h0, d);
        check("R2 other address reads 0", d, 0);
        rd(CTRL_A, d);
        check("R2 field layout", d, 6);

        // R3 forced level overrides frame high window
        check("R3 forced 1", sync_out, 1);
        wr(32'h4);
        check("R3 forced 0 in frame high window", sync_out, 0);

        // R4 level bit ignored when disabled
        wr(32'h2);
        check("R4 level ignored", sync_out, frame_model(bit_edges));

        // R8 frame window boundary
        wr(32'h0);
        for (int i = 0; i < 15; i++) bit_rise();
        check("R8 edge 15 still high", sync_out, 1);
        bit_rise();
        check("R8 edge 16 low", sync_out, 0);
        while (bit_edges < 255) bit_rise();
        check("R8 edge 255 low", sync_out, 0);
        bit_rise();
        check("R8 frame wrap high", sync_out, 1);
        for (int i = 0; i < 20; i++) bit_rise();
        check("R8 past window low", sync_out, frame_model(bit_edges));

        // R5 / R6 / R7 timed pulses at random phases
        for (int k = 0; k < 4; k++) begin
            repeat ($urandom_range(REF_P - 1, 0)) @(negedge clk);
            wr(32'h1);
            width = 0;
            while (sync_out && width < 10 * REF_P) begin
                if (width == REF_P) begin
                    rd(CTRL_A, d);
                    check("R6 bit reads 1 during pulse", d[0], 1);
                end
                @(negedge clk);
                width++;
            end
            check("R5 width low bound", (width >= 4 * REF_P - 3), 1);
            check("R5 width high bound", (width <= 5 * REF_P + 4), 1);
            rd(CTRL_A, d);
            check("R6 bit cleared after pulse", d[0], 0);
            check("R7 back to frame", sync_out, frame_model(bit_edges));
        end

        // R6 zero write and re-trigger do not alter pulse
        wr(32'h1);
        repeat (REF_P) @(negedge clk);
        wr(32'h0);
        rd(CTRL_A, d);
        check("R6 zero write keeps pulse", d[0], 1);
        check("R6 sync held high", sync_out, 1);
        wr(32'h1);
        wait_timed_clear(10 * REF_P, cyc);
        check("R6 retrigger not extended", (cyc <= 4 * REF_P + 4), 1);

        // R9 timed request under forced mode
        wr(32'h5);
        width = 0;
        cyc = 0;
        rd(CTRL_A, d);
        while (d[0] && cyc < 10 * REF_P) begin
            if (sync_out) width++;
            @(negedge clk);
            cyc++;
            rd(CTRL_A, d);
        end
        check("R9 sync stayed at forced 0", width, 0);
        check("R9 timed bit cleared", d[0], 0);
        check("R9 pulse length", (cyc >= 4 * REF_P - 3 && cyc <= 5 * REF_P + 4), 1);

        // Random mix of forced settings and frame advance
        for (int k = 0; k < 40; k++) begin
            fen = 1'($urandom_range(1, 0));
            flv = 1'($urandom_range(1, 0));
            wr({29'd0, fen, flv, 1'b0});
            for (int j = 0; j < int'($urandom_range(12, 0)); j++) bit_rise();
            rd(CTRL_A, d);
            check("R2 random readback", d, {29'd0, fen, flv, 1'b0});
            check(fen ? "R3 random forced" : "R4 random frame",
                  sync_out, sync_model(fen, flv, 1'b0, bit_edges));
        end

        finish_run();
    end

    initial begin
        process::self().srandom(32'h5EED_0097);
    end

endmodule